// File: doc/BRIEF.md
# Link-Loss Output State Controller

This block decides how the parallel output side of a serial-link receiver behaves as the link comes and goes. It watches an active-low power-down input and a per-cycle flag that reports whether the embedded clock bits of the serial stream were seen. From these it tracks one of four states. For the pixel clock, the parallel data (including sync and enable), the lock flag and the pass flag it drives a drive-enable (0 means high impedance) and a value or a live/forced-low control.

The state names are ST_PDOWN (deep power-down), ST_SLEEP (stream stopped, low power), ST_ACQ (acquiring lock) and ST_LOCKED. The transitions are: any state to ST_PDOWN while the power-down input is low; ST_PDOWN to ST_ACQ on release; ST_ACQ to ST_LOCKED after enough consecutive good symbols; ST_ACQ to ST_SLEEP after enough consecutive missing symbols; ST_LOCKED to ST_ACQ on the first missing symbol; ST_SLEEP to ST_ACQ on the first symbol seen. A select input chooses whether outputs are driven low or released to high impedance while there is no lock. Only deep power-down resets the companion control-register file. Stream-stop sleep keeps its contents.

Top module: `lk_outstate_ctrl`

## Requirements
- R1: One clock edge after pwr_dn_n is sampled low, lock_oe, pass_oe, pclk_oe and data_oe are all 0 (high impedance), whatever the other inputs are. This also holds while rst_n is low.
- R2: In ST_ACQ or ST_SLEEP with the effective select at 0, all four drive-enables are 1 and lock_o, pass_o, pclk_act and data_act are 0, so every output is driven low.
- R3: In ST_ACQ or ST_SLEEP with the effective select at 1, pclk_oe and data_oe are 0, lock_oe and pass_oe are 1, and lock_o and pass_o are 0.
- R4: In ST_LOCKED, all four drive-enables are 1 and lock_o, pass_o, pclk_act and data_act are all 1.
- R5: In ST_ACQ, lock_o rises at the edge that samples the LOCK_GOOD-th (default 8) consecutive cycle with clk_bits_seen=1. A cycle with clk_bits_seen=0 restarts the count.
- R6: In ST_ACQ, when the number of consecutive cycles with clk_bits_seen=0 reaches stop_limit (a value of 0 counts as 1), the state becomes ST_SLEEP and sleep_o is 1. The first cycle with clk_bits_seen=1 in ST_SLEEP returns the state to ST_ACQ.
- R7: creg_rst is 1 in ST_PDOWN (including during reset) and 0 in every other state, ST_SLEEP included.
- R8: In ST_LOCKED, one cycle with clk_bits_seen=0 makes lock_o and pass_o 0 at the next edge. The outputs then follow the select as in R2 and R3, and the stop count starts afresh in ST_ACQ.
- R9: The effective select is sel_reg when sel_reg_vld is 1. Otherwise it is the value of sel_strap captured at the first clock edge after reset is released.
- R10: When pwr_dn_n is sampled high in ST_PDOWN, the next state is ST_ACQ: lock_oe becomes 1 with lock_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn_n | input | 1 | Power-down, active low |
| sel_strap | input | 1 | Strap value for the no-lock output select |
| sel_reg | input | 1 | Register value for the no-lock output select |
| sel_reg_vld | input | 1 | Selects sel_reg in place of the captured strap |
| clk_bits_seen | input | 1 | Embedded clock bits were seen this cycle |
| stop_limit | input | MISS_W | Consecutive misses that declare a stopped stream |
| lock_o | output | 1 | Lock flag value |
| lock_oe | output | 1 | Lock flag drive-enable |
| pass_o | output | 1 | Pass flag value |
| pass_oe | output | 1 | Pass flag drive-enable |
| pclk_act | output | 1 | Pixel clock live (1) or held low (0) |
| pclk_oe | output | 1 | Pixel clock drive-enable |
| data_act | output | 1 | Parallel data live (1) or held low (0) |
| data_oe | output | 1 | Parallel data drive-enable |
| sleep_o | output | 1 | Stream-stop sleep state |
| creg_rst | output | 1 | Reset to the control-register file |

## Verification
Directed runs of good symbols stop one short of the lock count and are broken by a miss. They show whether the lock counter restarts or merely pauses. Miss runs against small and zero stop limits show exactly where ST_SLEEP is entered, and that creg_rst stays low there. The select is driven from the strap alone and then from the register override, which tells the low-drive pattern apart from the high-impedance one. A long random phase mixes power-down pulses with seen/missing patterns of varying density and compares every output each cycle against a reference model.

// File: rtl/lk_pkg.sv
package lk_pkg;
    typedef enum logic [1:0] {
        ST_PDOWN  = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_ACQ    = 2'd2,
        ST_LOCKED = 2'd3
    } lk_state_e;
endpackage

// File: rtl/lk_sel_resolve.sv
module lk_sel_resolve (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_strap,
    input  logic sel_reg,
    input  logic sel_reg_vld,
    output logic sel_eff
);
    logic strap_q;
    logic strap_done_q;

    // strap captured once, on the first edge after reset release
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_q      <= 1'b0;
            strap_done_q <= 1'b0;
        end else if (!strap_done_q) begin
            strap_q      <= sel_strap;
            strap_done_q <= 1'b1;
        end
    end

    assign sel_eff = sel_reg_vld ? sel_reg : strap_q;

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_done_q) |-> $stable(strap_q)) else $error("strap changed"); // R9
endmodule

// File: rtl/lk_sym_count.sv
module lk_sym_count #(
    parameter int LOCK_GOOD = 8,
    parameter int MISS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_acq,
    input  logic              seen,
    input  logic [MISS_W-1:0] limit,
    output logic              good_done,
    output logic              stop_hit
);
    localparam int GOOD_W = $clog2(LOCK_GOOD + 1);

    logic [GOOD_W-1:0] good_q;
    logic [MISS_W-1:0] miss_q;
    logic [MISS_W-1:0] lim_eff;

    assign lim_eff = (limit == '0) ? MISS_W'(1) : limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
            miss_q <= '0;
        end else if (!in_acq) begin
            good_q <= '0;
            miss_q <= '0;
        end else if (seen) begin
            miss_q <= '0;
            if (good_q != GOOD_W'(LOCK_GOOD)) good_q <= good_q + 1'b1;
        end else begin
            good_q <= '0;
            if (miss_q != '1) miss_q <= miss_q + 1'b1;
        end
    end

    assign good_done = in_acq && seen && (good_q == GOOD_W'(LOCK_GOOD - 1));
    assign stop_hit  = in_acq && !seen &&
                       (({1'b0, miss_q} + 1'b1) >= {1'b0, lim_eff});

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        good_q <= GOOD_W'(LOCK_GOOD)) else $error("good count overflow"); // R5
endmodule

// File: rtl/lk_fsm.sv
module lk_fsm
    import lk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn_n,
    input  logic seen,
    input  logic sel_eff,
    input  logic good_done,
    input  logic stop_hit,
    output logic in_acq,
    output logic lock_o,
    output logic lock_oe,
    output logic pass_o,
    output logic pass_oe,
    output logic pclk_act,
    output logic pclk_oe,
    output logic data_act,
    output logic data_oe,
    output logic sleep_o,
    output logic creg_rst
);
    lk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!pwr_dn_n) begin
            state_d = ST_PDOWN;
        end else begin
            unique case (state_q)
                ST_PDOWN:  state_d = ST_ACQ;
                ST_SLEEP:  if (seen) state_d = ST_ACQ;
                ST_ACQ: begin
                    if (good_done)     state_d = ST_LOCKED;
                    else if (stop_hit) state_d = ST_SLEEP;
                end
                ST_LOCKED: if (!seen) state_d = ST_ACQ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PDOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        lock_o = 1'b0; lock_oe = 1'b0; pass_o = 1'b0; pass_oe = 1'b0;
        pclk_act = 1'b0; pclk_oe = 1'b0; data_act = 1'b0; data_oe = 1'b0;
        sleep_o = 1'b0; creg_rst = 1'b0;
        unique case (state_q)
            ST_PDOWN: creg_rst = 1'b1;
            ST_SLEEP, ST_ACQ: begin
                sleep_o = (state_q == ST_SLEEP);
                lock_oe = 1'b1;
                pass_oe = 1'b1;
                pclk_oe = !sel_eff;
                data_oe = !sel_eff;
            end
            ST_LOCKED: begin
                lock_o = 1'b1; lock_oe = 1'b1; pass_o = 1'b1; pass_oe = 1'b1;
                pclk_act = 1'b1; pclk_oe = 1'b1; data_act = 1'b1; data_oe = 1'b1;
            end
        endcase
    end

    assign in_acq = (state_q == ST_ACQ);

    AST_PDN_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_dn_n |=> !(lock_oe || pass_oe || pclk_oe || data_oe)) else $error("pdown not hiz"); // R1
    AST_LOCK_NEEDS_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(seen) && $past(in_acq)) else $error("lock without symbol"); // R5
    AST_LOSS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && pwr_dn_n && !seen) |=> (!lock_o && in_acq)) else $error("lock held after loss"); // R8
    AST_SLEEP_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> !creg_rst) else $error("sleep reset regs"); // R7
    AST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && pwr_dn_n && seen) |=> in_acq) else $error("no wake"); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (creg_rst && pwr_dn_n) |=> (lock_oe && !lock_o)) else $error("release"); // R10
endmodule

// File: rtl/lk_outstate_ctrl.sv
module lk_outstate_ctrl #(
    parameter int LOCK_GOOD = 8,
    parameter int MISS_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn_n,
    input  logic              sel_strap,
    input  logic              sel_reg,
    input  logic              sel_reg_vld,
    input  logic              clk_bits_seen,
    input  logic [MISS_W-1:0] stop_limit,
    output logic              lock_o,
    output logic              lock_oe,
    output logic              pass_o,
    output logic              pass_oe,
    output logic              pclk_act,
    output logic              pclk_oe,
    output logic              data_act,
    output logic              data_oe,
    output logic              sleep_o,
    output logic              creg_rst
);
    logic sel_eff, in_acq, good_done, stop_hit;

    lk_sel_resolve u_sel (
        .clk(clk), .rst_n(rst_n), .sel_strap(sel_strap),
        .sel_reg(sel_reg), .sel_reg_vld(sel_reg_vld), .sel_eff(sel_eff)
    );

    lk_sym_count #(.LOCK_GOOD(LOCK_GOOD), .MISS_W(MISS_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .in_acq(in_acq), .seen(clk_bits_seen),
        .limit(stop_limit), .good_done(good_done), .stop_hit(stop_hit)
    );

    lk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .seen(clk_bits_seen),
        .sel_eff(sel_eff), .good_done(good_done), .stop_hit(stop_hit),
        .in_acq(in_acq), .lock_o(lock_o), .lock_oe(lock_oe), .pass_o(pass_o),
        .pass_oe(pass_oe), .pclk_act(pclk_act), .pclk_oe(pclk_oe),
        .data_act(data_act), .data_oe(data_oe), .sleep_o(sleep_o),
        .creg_rst(creg_rst)
    );
endmodule

// File: tb/lk_outstate_ctrl_tb.sv
module lk_outstate_ctrl_tb;
    localparam int MW = 8;
    localparam int LG = 8;

    logic clk = 1'b0;
    logic rst_n, pwr_dn_n, sel_strap, sel_reg, sel_reg_vld, seen;
    logic [MW-1:0] stop_limit;
    logic lock_o, lock_oe, pass_o, pass_oe, pclk_act, pclk_oe;
    logic data_act, data_oe, sleep_o, creg_rst;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model: 0 pdown, 1 sleep, 2 acq, 3 locked
    int m_st, m_good, m_miss;
    bit m_strap, m_sd;

    always #2 clk = ~clk;

    lk_outstate_ctrl #(.LOCK_GOOD(LG), .MISS_W(MW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n), .sel_strap(sel_strap),
        .sel_reg(sel_reg), .sel_reg_vld(sel_reg_vld), .clk_bits_seen(seen),
        .stop_limit(stop_limit), .lock_o(lock_o), .lock_oe(lock_oe),
        .pass_o(pass_o), .pass_oe(pass_oe), .pclk_act(pclk_act),
        .pclk_oe(pclk_oe), .data_act(data_act), .data_oe(data_oe),
        .sleep_o(sleep_o), .creg_rst(creg_rst)
    );

    function automatic bit sel_now();
        return sel_reg_vld ? sel_reg : m_strap;
    endfunction

    // order: lock_o lock_oe pass_o pass_oe pclk_act pclk_oe data_act data_oe sleep creg_rst
    function automatic logic [9:0] exp_vec(int st, bit s);
        case (st)
            0: return 10'b00_00_00_00_0_1;                       // R1 R7
            1: return {4'b0101, 1'b0, !s, 1'b0, !s, 2'b10};      // R6 with R2/R3
            2: return {4'b0101, 1'b0, !s, 1'b0, !s, 2'b00};      // R2 R3
            default: return 10'b11_11_11_11_0_0;                 // R4
        endcase
    endfunction

    function automatic string st_tag(int st, bit s);
        case (st)
            0: return "R1";
            1: return "R6";
            2: return s ? "R3" : "R2";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [9:0] act_vec();
        return {lock_o, lock_oe, pass_o, pass_oe, pclk_act, pclk_oe,
                data_act, data_oe, sleep_o, creg_rst};
    endfunction

    task automatic check_vec();
        logic [9:0] e;
        e = exp_vec(m_st, sel_now());
        checks++;
        if (act_vec() !== e) begin
            errors++;
            $display("FAIL %s state=%0d actual=%b expected=%b", st_tag(m_st, sel_now()),
                     m_st, act_vec(), e);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic model_step();
        int lim;
        lim = (stop_limit == 0) ? 1 : int'(stop_limit);
        if (!m_sd) begin m_strap = sel_strap; m_sd = 1'b1; end
        if (m_st == 2) begin
            if (!pwr_dn_n) begin m_st = 0; m_good = 0; m_miss = 0; end
            else if (seen) begin
                m_miss = 0;
                if (m_good == LG - 1) begin m_st = 3; m_good = 0; end
                else m_good++;
            end else begin
                m_good = 0;
                if (m_miss + 1 >= lim) begin m_st = 1; m_miss = 0; end
                else m_miss++;
            end
        end else begin
            m_good = 0; m_miss = 0;
            if (!pwr_dn_n) m_st = 0;
            else if (m_st == 0) m_st = 2;
            else if (m_st == 1 && seen) m_st = 2;
            else if (m_st == 3 && !seen) m_st = 2;
        end
    endtask

    // inputs set before this call (away from edges); one edge, model update, compare
    task automatic cyc();
        @(posedge clk);
        model_step();
        #1;
        check_vec();
    endtask

    task automatic run(int n, bit s);
        for (int i = 0; i < n; i++) begin seen = s; cyc(); end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; pwr_dn_n = 1'b1; sel_strap = 1'b1; sel_reg = 1'b0;
        sel_reg_vld = 1'b0; seen = 1'b1; stop_limit = 8'd16;
        m_st = 0; m_good = 0; m_miss = 0; m_strap = 1'b0; m_sd = 1'b0;
        #9;
        // reset state: high impedance everywhere, register reset asserted
        check_bit("R1 reset lock_oe", lock_oe, 1'b0);
        check_bit("R1 reset pclk_oe", pclk_oe, 1'b0);
        check_bit("R7 reset creg_rst", creg_rst, 1'b1);
        @(negedge clk); rst_n = 1'b1; pwr_dn_n = 1'b0;
        run(3, 1'b1);                       // strap=1 captured here
        check_bit("R7 pdown creg_rst", creg_rst, 1'b1);
        @(negedge clk); pwr_dn_n = 1'b1; seen = 1'b0;
        cyc();
        // R10: lock driven low after release; R9: strap=1 -> clock high-Z
        check_bit("R10 lock_oe after release", lock_oe, 1'b1);
        check_bit("R10 lock_o after release", lock_o, 1'b0);
        check_bit("R9 strap high pclk_oe", pclk_oe, 1'b0);
        @(negedge clk); sel_reg_vld = 1'b1; sel_reg = 1'b0; #1;
        check_bit("R9 register override pclk_oe", pclk_oe, 1'b1);
        check_bit("R2 data driven low", data_act, 1'b0);
        // R5: seven good, a miss, then eight good
        @(negedge clk); run(7, 1'b1);
        check_bit("R5 no lock after 7", lock_o, 1'b0);
        run(1, 1'b0);
        run(7, 1'b1);
        check_bit("R5 count restarted", lock_o, 1'b0);
        run(1, 1'b1);
        check_bit("R5 lock after 8", lock_o, 1'b1);
        check_bit("R4 pass high", pass_o, 1'b1);
        // R8: one miss drops lock
        run(1, 1'b0);
        check_bit("R8 lock drops", lock_o, 1'b0);
        check_bit("R8 pclk driven low", pclk_oe & ~pclk_act, 1'b1);
        // R6: stop after limit misses, wake on symbol, regs kept (R7)
        @(negedge clk); stop_limit = 8'd3;
        run(2, 1'b0);
        check_bit("R6 not yet asleep", sleep_o, 1'b0);
        run(1, 1'b0);
        check_bit("R6 asleep after limit", sleep_o, 1'b1);
        check_bit("R7 sleep keeps regs", creg_rst, 1'b0);
        run(1, 1'b1);
        check_bit("R6 wake on symbol", sleep_o, 1'b0);
        @(negedge clk); stop_limit = 8'd0;
        run(1, 1'b0);
        check_bit("R6 zero limit acts as one", sleep_o, 1'b1);
        // R3 via register high
        @(negedge clk); sel_reg = 1'b1; #1;
        check_bit("R3 data high-Z", data_oe, 1'b0);
        check_bit("R3 pass driven", pass_oe, 1'b1);
        // R1 power-down overrides lock
        @(negedge clk); stop_limit = 8'd16; run(LG + 1, 1'b1);
        @(negedge clk); pwr_dn_n = 1'b0; cyc();
        check_bit("R1 pdown from lock", lock_oe | pclk_oe | data_oe | pass_oe, 1'b0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            int dens;
            @(negedge clk);
            dens = (i / 500) % 4;
            pwr_dn_n = ($urandom % 64) != 0;
            seen = (($urandom % 8) < (2 + 2 * dens));
            if (($urandom % 32) == 0) sel_reg_vld = $urandom % 2;
            if (($urandom % 32) == 0) sel_reg = $urandom % 2;
            if (($urandom % 128) == 0) stop_limit = MW'($urandom % 6);
            cyc();
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule